// File: doc/BRIEF.md
# Card Host Status Word and Interrupt Masking

This block keeps the status word of a memory-card host controller and derives two interrupt lines from it. The status word has two parts. The low part holds sticky event flags. The command and data units set these flags with single-cycle pulses, and software clears them by writing ones. The upper part holds live flags that describe the data FIFO. These are recomputed every cycle from the FIFO fill level, the transfer direction and whether the data engine is idle. A separate live flag shows that a command is in flight.

Each interrupt line has its own 32-bit mask register. A line is high whenever the status word ANDed with that line's mask is nonzero. The block exposes the status word, both masks, a clear strobe with its data and a write strobe for each mask. Address decoding, FIFO storage and the card interface live in neighbouring units.

Top module: `mmc_status_irq`

## Requirements
- R1: After a synchronous reset, the status word, both masks and both interrupt lines are zero.
- R2: An `evt_set` pulse on bit k (k in 0..8 or 10) sets status bit k on the next clock edge. The bit then stays set after the pulse ends, until it is cleared.
- R3: A cycle with `clr_we` high clears each status bit in 10:0 whose bit in `clr_data` is one. Bits 31:11 of `clr_data` have no effect on the status word.
- R4: If a set pulse and a clear of the same bit fall in the same cycle, the bit is set after the edge.
- R5: `irq_o[i]` equals the OR of (status AND mask i), where i is 0 or 1. A mask write with `mask_we[i]` takes effect on the next edge.
- R6: The FIFO flags are registered from `fifo_level` with a FIFO depth of 16. The rules are: active when the engine is not idle, empty at level 0, data available above 0, full at 16, half-empty at 8 or less, and half-full at 8 or more.
- R7: When `xfer_rx` is 1, only the receive flags are shown: bits 13 active, 15 half-full, 17 full, 19 empty and 21 available. When `xfer_rx` is 0, only the transmit flags are shown: bits 12 active, 14 half-empty, 16 full, 18 empty and 20 available.
- R8: While `xfer_idle` is high, all of bits 12 to 21 are zero after the next edge.
- R9: Status bit 11 shows `cmd_busy`, one edge late.
- R10: Status bit 9 and bits 31:22 always read zero, and a set pulse on bit 9 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 11 | One-cycle set pulses for event bits 10:0 |
| cmd_busy | input | 1 | A command is in progress |
| xfer_rx | input | 1 | Transfer direction, 1 = card to host |
| xfer_idle | input | 1 | Data engine idle (no bytes left, FIFO empty) |
| fifo_level | input | 5 | FIFO fill level, 0 to 16 words |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 32 | Clear value |
| mask_we | input | 2 | Write strobe per mask register |
| mask_wdata | input | 32 | Mask write value |
| status_rd | output | 32 | Status word |
| mask0_rd | output | 32 | Mask register 0 |
| mask1_rd | output | 32 | Mask register 1 |
| irq_o | output | 2 | Interrupt lines 1:0 |

## Verification
Every register in the block updates on the clock edge after its inputs are presented. The interrupt lines are formed combinationally from those registers, so they settle in the same cycle as the status word. Each bench step drives inputs on a falling edge, waits for the following rising edge, and compares the status word, both masks and both interrupt lines on the next falling edge. A reference model in the bench advances by exactly one edge per step. Directed steps cover set/clear collisions, clear data with high bits set, the level boundaries 0, 7, 8, 9 and 16, idle entry and both directions; seeded random steps cover the rest.

// File: rtl/mmc_stat_pkg.sv
package mmc_stat_pkg;
    localparam int STAT_W     = 32;
    localparam int EVT_W      = 11;
    localparam int FIFO_DEPTH = 16;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
    localparam int HALF_LVL   = FIFO_DEPTH / 2;
    localparam int NUM_IRQ    = 2;

    localparam int BIT_RSVD   = 9;
    localparam int BIT_CMDACT = 11;
    localparam int BIT_ACT    = 12;
    localparam int BIT_HALF   = 14;
    localparam int BIT_FULL   = 16;
    localparam int BIT_EMPTY  = 18;
    localparam int BIT_AVAIL  = 20;

    localparam logic [EVT_W-1:0] EVT_VALID = ~(EVT_W'(1) << BIT_RSVD);

    localparam logic [STAT_W-1:0] TX_GROUP =
        (STAT_W'(1) << BIT_ACT)   | (STAT_W'(1) << BIT_HALF) |
        (STAT_W'(1) << BIT_FULL)  | (STAT_W'(1) << BIT_EMPTY) |
        (STAT_W'(1) << BIT_AVAIL);
    localparam logic [STAT_W-1:0] RX_GROUP = TX_GROUP << 1;

    typedef struct packed {
        logic active;
        logic half;
        logic full;
        logic empty;
        logic avail;
    } fifo_flags_t;

    function automatic fifo_flags_t level_flags(input logic [LVL_W-1:0] lvl,
                                                input logic rx,
                                                input logic idle);
        fifo_flags_t f;
        f.active = !idle;
        f.empty  = !idle && (lvl == '0);
        f.avail  = !idle && (lvl != '0);
        f.full   = !idle && (lvl == LVL_W'(FIFO_DEPTH));
        f.half   = !idle && (rx ? (lvl >= LVL_W'(HALF_LVL)) : (lvl <= LVL_W'(HALF_LVL)));
        return f;
    endfunction

    function automatic logic [STAT_W-1:0] place_flags(input fifo_flags_t f,
                                                      input logic rx);
        logic [STAT_W-1:0] w;
        w = '0;
        w[BIT_ACT]   = f.active;
        w[BIT_HALF]  = f.half;
        w[BIT_FULL]  = f.full;
        w[BIT_EMPTY] = f.empty;
        w[BIT_AVAIL] = f.avail;
        return rx ? (w << 1) : w;
    endfunction
endpackage

// File: rtl/stat_event_bank.sv
module stat_event_bank
    import mmc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] set_i,
    input  logic             clr_we,
    input  logic [EVT_W-1:0] clr_bits,
    output logic [EVT_W-1:0] ev_q
);
    logic [EVT_W-1:0] set_v;
    logic [EVT_W-1:0] clr_v;

    assign set_v = set_i & EVT_VALID;
    assign clr_v = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) ev_q <= '0;
        else     ev_q <= (ev_q & ~clr_v) | set_v;
    end

    // R2 / R4: a pulse always lands, whatever the clear does
    assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((ev_q & $past(set_v)) == $past(set_v)));

    // R3: cleared bits without a competing set read zero
    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((ev_q & $past(clr_bits & ~set_v)) == '0));

    // R2: bits not cleared stay set
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

    // R10: reserved position never sets
    assert_rsvd_R10: assert property (@(posedge clk) disable iff (rst)
        set_i[BIT_RSVD] |=> !ev_q[BIT_RSVD]);
endmodule

// File: rtl/stat_cond_track.sv
module stat_cond_track
    import mmc_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              rx_i,
    input  logic              idle_i,
    input  logic              cmd_busy_i,
    output logic [STAT_W-1:0] cond_q
);
    fifo_flags_t       flags;
    logic [STAT_W-1:0] cond_d;

    always_comb begin
        flags  = level_flags(lvl_i, rx_i, idle_i);
        cond_d = place_flags(flags, rx_i);
        cond_d[BIT_CMDACT] = cmd_busy_i;
    end

    always_ff @(posedge clk) begin
        if (rst) cond_q <= '0;
        else     cond_q <= cond_d;
    end

    // R7: never both groups at once
    assert_one_group_R7: assert property (@(posedge clk) disable iff (rst)
        !(((cond_q & TX_GROUP) != '0) && ((cond_q & RX_GROUP) != '0)));

    // R8: idle clears every FIFO flag
    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (rst)
        idle_i |=> ((cond_q & (TX_GROUP | RX_GROUP)) == '0));

    // R9: command activity tracks input
    assert_cmd_act_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_busy_i |=> cond_q[BIT_CMDACT]);

    // R6: empty and available are exclusive
    assert_empty_avail_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(cond_q & ((STAT_W'(3) << BIT_EMPTY) | (STAT_W'(3) << BIT_AVAIL))) <= 1);
endmodule

// File: rtl/stat_irq_lines.sv
module stat_irq_lines
    import mmc_stat_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [STAT_W-1:0]         status_i,
    input  logic [NUM_IRQ-1:0]        mask_we,
    input  logic [STAT_W-1:0]         mask_wdata,
    output logic [NUM_IRQ*STAT_W-1:0] mask_flat,
    output logic [NUM_IRQ-1:0]        irq_o
);
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        logic [STAT_W-1:0] mask_q;

        always_ff @(posedge clk) begin
            if (rst)             mask_q <= '0;
            else if (mask_we[g]) mask_q <= mask_wdata;
        end

        assign mask_flat[g*STAT_W +: STAT_W] = mask_q;
        assign irq_o[g] = |(status_i & mask_q);

        // R5: a zero mask silences the line
        assert_zero_mask_quiet_R5: assert property (@(posedge clk) disable iff (rst)
            (mask_we[g] && (mask_wdata == '0)) |=> !irq_o[g]);
    end
endmodule

// File: rtl/mmc_status_irq.sv
module mmc_status_irq
    import mmc_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt_set,
    input  logic              cmd_busy,
    input  logic              xfer_rx,
    input  logic              xfer_idle,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_data,
    input  logic [NUM_IRQ-1:0] mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status_rd,
    output logic [STAT_W-1:0] mask0_rd,
    output logic [STAT_W-1:0] mask1_rd,
    output logic [NUM_IRQ-1:0] irq_o
);
    logic [EVT_W-1:0]          ev_q;
    logic [STAT_W-1:0]         cond_q;
    logic [NUM_IRQ*STAT_W-1:0] mask_flat;

    stat_event_bank u_events (
        .clk      (clk),
        .rst      (rst),
        .set_i    (evt_set),
        .clr_we   (clr_we),
        .clr_bits (clr_data[EVT_W-1:0]),
        .ev_q     (ev_q)
    );

    stat_cond_track u_cond (
        .clk        (clk),
        .rst        (rst),
        .lvl_i      (fifo_level),
        .rx_i       (xfer_rx),
        .idle_i     (xfer_idle),
        .cmd_busy_i (cmd_busy),
        .cond_q     (cond_q)
    );

    assign status_rd = cond_q | {{(STAT_W-EVT_W){1'b0}}, ev_q};

    stat_irq_lines u_irq (
        .clk        (clk),
        .rst        (rst),
        .status_i   (status_rd),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .mask_flat  (mask_flat),
        .irq_o      (irq_o)
    );

    assign mask0_rd = mask_flat[0 +: STAT_W];
    assign mask1_rd = mask_flat[STAT_W +: STAT_W];

    // R3: high clear bits leave the live flags alone
    assert_clear_keeps_live_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_we && $stable(fifo_level) && $stable(xfer_rx) && $stable(xfer_idle)
         && $stable(cmd_busy)) |=> (status_rd[STAT_W-1:EVT_W] == $past(status_rd[STAT_W-1:EVT_W])));
endmodule

// File: tb/mmc_status_irq_tb.sv
module mmc_status_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] evt_set;
    logic        cmd_busy, xfer_rx, xfer_idle;
    logic [4:0]  fifo_level;
    logic        clr_we;
    logic [31:0] clr_data;
    logic [1:0]  mask_we;
    logic [31:0] mask_wdata;
    logic [31:0] status_rd, mask0_rd, mask1_rd;
    logic [1:0]  irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [10:0] m_ev;
    logic [31:0] m_cond, m_mask0, m_mask1;

    always #2.5 clk = ~clk;

    mmc_status_irq dut_i (
        .clk(clk), .rst(rst), .evt_set(evt_set), .cmd_busy(cmd_busy),
        .xfer_rx(xfer_rx), .xfer_idle(xfer_idle), .fifo_level(fifo_level),
        .clr_we(clr_we), .clr_data(clr_data), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .status_rd(status_rd), .mask0_rd(mask0_rd),
        .mask1_rd(mask1_rd), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_cond(input logic [4:0] lvl, input logic rx,
                                             input logic idle, input logic cb);
        logic [31:0] w;
        int o;
        w = '0;
        w[11] = cb;
        if (!idle) begin
            o = rx ? 1 : 0;
            w[12+o] = 1'b1;
            w[14+o] = rx ? (lvl >= 8) : (lvl <= 8);
            w[16+o] = (lvl == 16);
            w[18+o] = (lvl == 0);
            w[20+o] = (lvl != 0);
        end
        return w;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] s;
        s = m_cond | {21'b0, m_ev};
        check(tag, "status", status_rd, s);
        check(tag, "mask0", mask0_rd, m_mask0);
        check(tag, "mask1", mask1_rd, m_mask1);
        check(tag, "irq", {30'b0, irq_o}, {30'b0, |(s & m_mask1), |(s & m_mask0)});
    endtask

    task automatic step(input logic [10:0] ev, input logic cb, input logic rx,
                        input logic idle, input logic [4:0] lvl, input logic cwe,
                        input logic [31:0] cdat, input logic [1:0] mwe,
                        input logic [31:0] mdat, input string tag);
        evt_set = ev; cmd_busy = cb; xfer_rx = rx; xfer_idle = idle;
        fifo_level = lvl; clr_we = cwe; clr_data = cdat;
        mask_we = mwe; mask_wdata = mdat;
        m_ev = (m_ev & ~(cwe ? cdat[10:0] : 11'h0)) | (ev & 11'h5FF);
        m_cond = exp_cond(lvl, rx, idle, cb);
        if (mwe[0]) m_mask0 = mdat;
        if (mwe[1]) m_mask1 = mdat;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        evt_set = '1; cmd_busy = 1; xfer_rx = 0; xfer_idle = 0; fifo_level = 5'd3;
        clr_we = 0; clr_data = 0; mask_we = 2'b11; mask_wdata = '1;
        m_ev = '0; m_cond = '0; m_mask0 = '0; m_mask1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst = 1'b0;

        // R2 set and sticky; R10 bit 9 ignored
        step(11'h001, 0, 0, 1, 0, 0, 0, 2'b00, 0, "R2");
        step(11'h000, 0, 0, 1, 0, 0, 0, 2'b00, 0, "R2");
        step(11'h200, 0, 0, 1, 0, 0, 0, 2'b00, 0, "R10");
        step(11'h5FE, 0, 0, 1, 0, 0, 0, 2'b00, 0, "R2");
        // R3 clear with high bits set, live flags active
        step(11'h000, 1, 0, 0, 5'd4, 1, 32'hFFFF_F003, 2'b00, 0, "R3");
        // R4 set and clear collide
        step(11'h040, 1, 0, 0, 5'd4, 1, 32'h0000_0040, 2'b00, 0, "R4");
        // R5 masks and irq
        step(11'h000, 0, 0, 1, 0, 0, 0, 2'b01, 32'h0000_0040, "R5");
        step(11'h000, 0, 0, 1, 0, 0, 0, 2'b10, 32'h0000_0800, "R5");
        step(11'h000, 1, 0, 1, 0, 0, 0, 2'b00, 0, "R9");
        step(11'h000, 0, 0, 1, 0, 1, 32'h0000_07FF, 2'b00, 0, "R5");
        // R6/R7 level boundaries in both directions
        for (int d = 0; d < 2; d++) begin
            step(0, 0, d[0], 0, 5'd0,  0, 0, 2'b00, 0, "R6");
            step(0, 0, d[0], 0, 5'd7,  0, 0, 2'b00, 0, "R6");
            step(0, 0, d[0], 0, 5'd8,  0, 0, 2'b00, 0, "R6");
            step(0, 0, d[0], 0, 5'd9,  0, 0, 2'b00, 0, "R7");
            step(0, 0, d[0], 0, 5'd16, 0, 0, 2'b11, 32'h003F_F000, "R7");
        end
        // R8 idle entry
        step(0, 0, 1, 1, 5'd16, 0, 0, 2'b00, 0, "R8");
        step(0, 0, 0, 1, 5'd0, 0, 0, 2'b00, 0, "R8");

        for (int i = 0; i < 400; i++) begin
            logic [1:0] mwe;
            mwe = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            step(11'($urandom & $urandom & $urandom), 1'($urandom),
                 1'($urandom), (($urandom % 4) == 0),
                 5'($urandom % 17), (($urandom % 3) == 0), $urandom,
                 mwe, $urandom & $urandom, "R2/R3/R5/R6 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule